// File: doc/BRIEF.md
# I2C START Condition Qualifier

This block sits at the front of an I2C slave receiver and decides whether a falling edge on the data line is a real START condition or noise. Both bus lines first pass through a synchronizer. When the synchronized data line drops from 1 to 0 while the clock line is high, the block treats this as a candidate and samples the bus again on each of the next system clocks. The candidate is confirmed only if every sample still shows data low and clock high.

A setup register picks the number of samples. Its top bit turns multi-sampling on and its low seven bits set the sample count. With multi-sampling off, one sample is taken. A second register holds the slave's own 7-bit address and passes it on to the address-matching logic that follows. The result is reported as a one-cycle `start_valid` pulse or a one-cycle `start_rejected` pulse.

The FSM has four states. IDLE waits for a candidate and moves to CHECK when it sees one. CHECK takes one sample per clock. It moves to REJECT on any failing sample, moves to ACCEPT when the last sample passes, and otherwise stays in CHECK. ACCEPT raises `start_valid` for one cycle and REJECT raises `start_rejected` for one cycle. Both of them always return to IDLE on the next clock.

Top module: `i2c_start_qualifier`

## Requirements
- R1: After reset, the setup register and the address register both read 0x00, and neither result pulse is asserted.
- R2: A candidate is formed only when the synchronized data line falls from 1 to 0 while the synchronized clock line is 1. A data fall while the clock line is 0 produces no pulse.
- R3: With setup bit 7 clear, exactly one sample is taken. If the data input falls just before clock edge E0 and the bus then stays put, `start_valid` is high in the cycle after edge E3, so it is seen 4 clocks after the drive.
- R4: With setup bit 7 set, the number of samples is bits 6:0 plus one, so a field of 0 behaves like R3. `start_valid` appears 3+N clocks after the data fall, where N is the number of samples. The samples are taken on consecutive system clocks.
- R5: A sample that shows data high or clock low ends validation immediately. The block then gives a single-cycle `start_rejected` pulse and no `start_valid`.
- R6: When the last sample passes, `start_valid` pulses for exactly one cycle. The two pulses are never high together.
- R7: After a result pulse the block returns to IDLE. A data fall that arrives while the block is not in IDLE is ignored and does not start a new candidate.
- R8: The sample count is captured when a candidate is detected. A setup write during validation changes only later candidates.
- R9: With `wr_sel`=0 a write goes to the setup register, and with `wr_sel`=1 it goes to the address register. `rd_sel` selects the read source the same way. The address occupies bits 7:1, bit 0 always reads 0 and ignores writes, and `own_addr` carries bits 7:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 setup, 1 address |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 setup, 1 address |
| rd_data | output | 8 | Read data of the selected register |
| own_addr | output | 7 | Stored slave address for address matching |
| start_valid | output | 1 | One-cycle pulse for a confirmed START |
| start_rejected | output | 1 | One-cycle pulse for a rejected candidate |

## Verification
The assertions check on every cycle that the two pulses are exclusive and last a single cycle, and that a bad sample in CHECK is followed by a rejection. They also check that an acceptance is always preceded by a passing sample, that the FSM returns to IDLE after each result, and that the address bit 0 reads as zero. The bench scenarios are needed to show the things a single cycle cannot. These are the exact latency for a given sample count, the capture of the count at detection time, the silence after a data fall with the clock low, and the way a re-fall after a glitch is swallowed.

// File: rtl/i2csq_pkg.sv
package i2csq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHECK  = 2'd1,
        ST_ACCEPT = 2'd2,
        ST_REJECT = 2'd3
    } qual_state_e;

    localparam int REG_W = 8;

endpackage

// File: rtl/i2csq_sync.sv
module i2csq_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] d,
    output logic [LINES-1:0] q
);

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '1;
                end else if (STAGES == 1) begin
                    chain <= d[g];
                end else begin
                    chain <= {chain[STAGES-2:0], d[g]};
                end
            end
            assign q[g] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/i2csq_edge.sv
module i2csq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_cand
);

    logic sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_prev <= 1'b1;
        end else begin
            sda_prev <= sda_s;
        end
    end

    assign start_cand = sda_prev & ~sda_s & scl_s;

endmodule

// File: rtl/i2csq_regs.sv
module i2csq_regs #(
    parameter int REG_W = 8,
    localparam int FLD_W = REG_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic             ms_enable,
    output logic [FLD_W-1:0] ms_field,
    output logic [FLD_W-1:0] own_addr
);

    logic [REG_W-1:0] setup_q;
    logic [FLD_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            setup_q <= '0;
            addr_q  <= '0;
        end else if (wr_en) begin
            if (wr_sel) begin
                addr_q <= wr_data[REG_W-1:1];
            end else begin
                setup_q <= wr_data;
            end
        end
    end

    assign rd_data   = rd_sel ? {addr_q, 1'b0} : setup_q;
    assign ms_enable = setup_q[REG_W-1];
    assign ms_field  = setup_q[FLD_W-1:0];
    assign own_addr  = addr_q;

endmodule

// File: rtl/i2csq_fsm.sv
module i2csq_fsm
    import i2csq_pkg::*;
#(
    parameter int FLD_W = 7,
    localparam int CNT_W = FLD_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_cand,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             ms_enable,
    input  logic [FLD_W-1:0] ms_field,
    output logic             start_valid,
    output logic             start_rejected,
    output qual_state_e      state_o
);

    qual_state_e state, state_nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_idx;
    logic             sample_bad;
    logic             sample_last;

    assign sample_bad  = sda_s | ~scl_s;
    assign sample_last = (cnt == last_idx);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Sample counter and captured window length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            last_idx <= '0;
        end else if (state == ST_IDLE && start_cand) begin
            cnt      <= '0;
            last_idx <= ms_enable ? {1'b0, ms_field} : '0;
        end else if (state == ST_CHECK) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start_cand) state_nxt = ST_CHECK;
            end
            ST_CHECK: begin
                if (sample_bad)       state_nxt = ST_REJECT;
                else if (sample_last) state_nxt = ST_ACCEPT;
                else                  state_nxt = ST_CHECK;
            end
            ST_ACCEPT: state_nxt = ST_IDLE;
            ST_REJECT: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        start_valid    = 1'b0;
        start_rejected = 1'b0;
        unique case (state)
            ST_ACCEPT: start_valid    = 1'b1;
            ST_REJECT: start_rejected = 1'b1;
            default: begin
                start_valid    = 1'b0;
                start_rejected = 1'b0;
            end
        endcase
    end

    assign state_o = state;

endmodule

// File: rtl/i2c_start_qualifier.sv
module i2c_start_qualifier
    import i2csq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    localparam int FLD_W = REG_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic [FLD_W-1:0] own_addr,
    output logic             start_valid,
    output logic             start_rejected
);

    logic [1:0]       bus_sync;
    logic             scl_sync;
    logic             sda_sync;
    logic             start_cand;
    logic             ms_enable;
    logic [FLD_W-1:0] ms_field;
    qual_state_e      fsm_state;

    i2csq_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (bus_sync)
    );

    assign scl_sync = bus_sync[1];
    assign sda_sync = bus_sync[0];

    i2csq_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (scl_sync),
        .sda_s      (sda_sync),
        .start_cand (start_cand)
    );

    i2csq_regs #(.REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .ms_enable (ms_enable),
        .ms_field  (ms_field),
        .own_addr  (own_addr)
    );

    i2csq_fsm #(.FLD_W(FLD_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_cand     (start_cand),
        .scl_s          (scl_sync),
        .sda_s          (sda_sync),
        .ms_enable      (ms_enable),
        .ms_field       (ms_field),
        .start_valid    (start_valid),
        .start_rejected (start_rejected),
        .state_o        (fsm_state)
    );

endmodule

// File: rtl/i2csq_checker.sv
module i2csq_checker
    import i2csq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start_valid,
    input logic        start_rejected,
    input logic        rd_sel,
    input logic [7:0]  rd_data,
    input logic        scl_s,
    input logic        sda_s,
    input qual_state_e state
);

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_valid && start_rejected)); // R6

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |=> !start_valid); // R6

    AST_REJECT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_rejected |=> !start_rejected); // R5

    AST_REJECT_ON_BAD_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && (sda_s || !scl_s)) |=> start_rejected); // R5

    AST_VALID_AFTER_GOOD_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> ($past(state == ST_CHECK) && $past(!sda_s && scl_s))); // R4

    AST_IDLE_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid || start_rejected) |=> state == ST_IDLE); // R7

    AST_ADDR_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel |-> !rd_data[0]); // R9

endmodule

bind i2c_start_qualifier i2csq_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_valid    (start_valid),
    .start_rejected (start_rejected),
    .rd_sel         (rd_sel),
    .rd_data        (rd_data),
    .scl_s          (scl_sync),
    .sda_s          (sda_sync),
    .state          (fsm_state)
);

// File: tb/sim_i2c_start_qualifier.sv
module sim_i2c_start_qualifier;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic [6:0] own_addr;
    logic       start_valid;
    logic       start_rejected;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_start_qualifier u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_in         (scl_in),
        .sda_in         (sda_in),
        .wr_en          (wr_en),
        .wr_sel         (wr_sel),
        .wr_data        (wr_data),
        .rd_sel         (rd_sel),
        .rd_data        (rd_data),
        .own_addr       (own_addr),
        .start_valid    (start_valid),
        .start_rejected (start_rejected)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: bus history queues plus a phase counter
    bit sda_h[$] = '{1'b1, 1'b1, 1'b1};
    bit scl_h[$] = '{1'b1, 1'b1, 1'b1};
    int m_phase = 0;     // 0 waiting, 1 sampling, 2 accepted, 3 rejected
    int m_left  = 0;     // samples still to take
    int m_setup = 0;
    int m_addr  = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            sda_h = '{1'b1, 1'b1, 1'b1};
            scl_h = '{1'b1, 1'b1, 1'b1};
            m_phase = 0;
            m_left  = 0;
            m_setup = 0;
            m_addr  = 0;
        end else begin
            case (m_phase)
                0: if (sda_h[2] && !sda_h[1] && scl_h[1]) begin
                       m_phase = 1;
                       m_left  = (m_setup >= 128) ? (m_setup % 128) + 1 : 1;
                   end
                1: begin
                       if (sda_h[1] || !scl_h[1]) m_phase = 3;
                       else begin
                           m_left--;
                           if (m_left == 0) m_phase = 2;
                       end
                   end
                default: m_phase = 0;
            endcase
            if (wr_en) begin
                if (wr_sel) m_addr = int'(wr_data) / 2;
                else        m_setup = int'(wr_data);
            end
            sda_h.push_front(sda_in);
            void'(sda_h.pop_back());
            scl_h.push_front(scl_in);
            void'(scl_h.pop_back());
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(start_valid == (m_phase == 2), "R6 start_valid vs model",
                  int'(start_valid), int'(m_phase == 2));
            check(start_rejected == (m_phase == 3), "R5 start_rejected vs model",
                  int'(start_rejected), int'(m_phase == 3));
            check(int'(rd_data) == (rd_sel ? m_addr * 2 : m_setup), "R9 rd_data vs model",
                  int'(rd_data), rd_sel ? m_addr * 2 : m_setup);
            check(int'(own_addr) == m_addr, "R9 own_addr vs model", int'(own_addr), m_addr);
        end
    end

    task automatic write_reg(input bit sel, input logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_idle();
        @(negedge clk);
        scl_in = 1'b1; sda_in = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // Drops SDA, then watches for 'limit' clocks with optional mid-window events
    task automatic observe(input int limit, input int rise_at, input int refall_at,
                           input int sclfall_at, input int wr_at, input logic [7:0] wr_val,
                           output int lat_v, output int nv, output int nr);
        @(negedge clk);
        sda_in = 1'b0;
        lat_v = -1; nv = 0; nr = 0;
        for (int k = 1; k <= limit; k++) begin
            @(negedge clk);
            if (start_valid) begin
                nv++;
                if (lat_v < 0) lat_v = k;
            end
            if (start_rejected) nr++;
            if (k == rise_at)    sda_in = 1'b1;
            if (k == refall_at)  sda_in = 1'b0;
            if (k == sclfall_at) scl_in = 1'b0;
            if (k == wr_at) begin
                wr_en = 1'b1; wr_sel = 1'b0; wr_data = wr_val;
            end else if (k == wr_at + 1) begin
                wr_en = 1'b0;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int lat, nv, nr;
        repeat (3) @(negedge clk);
        // R1 reset values
        check(start_valid == 1'b0 && start_rejected == 1'b0, "R1 no pulse in reset",
              int'(start_valid | start_rejected), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_sel = 1'b0;
        #1 check(rd_data == 8'h00, "R1 setup reset", int'(rd_data), 0);
        rd_sel = 1'b1;
        #1 check(rd_data == 8'h00, "R1 address reset", int'(rd_data), 0);
        rd_sel = 1'b0;

        // R3 single sample, clean START
        bus_idle();
        observe(30, 0, 0, 0, 0, 8'h00, lat, nv, nr);
        check(lat == 4, "R3 latency single sample", lat, 4);
        check(nv == 1 && nr == 0, "R6 exactly one start_valid", nv, 1);

        // R2 data falls while clock low
        bus_idle();
        @(negedge clk); scl_in = 1'b0;
        repeat (3) @(negedge clk);
        observe(30, 0, 0, 0, 0, 8'h00, lat, nv, nr);
        check(nv == 0 && nr == 0, "R2 no candidate with clock low", nv + nr, 0);

        // R4 field 5 with enable: 6 samples
        bus_idle();
        write_reg(1'b0, 8'h85);
        observe(40, 0, 0, 0, 0, 8'h00, lat, nv, nr);
        check(lat == 9, "R4 latency six samples", lat, 9);

        // R4 field 0 with enable behaves like one sample
        bus_idle();
        write_reg(1'b0, 8'h80);
        observe(30, 0, 0, 0, 0, 8'h00, lat, nv, nr);
        check(lat == 4, "R4 field zero latency", lat, 4);

        // R4 field set but enable clear: still single sample
        bus_idle();
        write_reg(1'b0, 8'h0A);
        observe(30, 0, 0, 0, 0, 8'h00, lat, nv, nr);
        check(lat == 4, "R4 field ignored without enable", lat, 4);

        // R5 data glitch back high inside window
        bus_idle();
        write_reg(1'b0, 8'h85);
        observe(40, 2, 0, 0, 0, 8'h00, lat, nv, nr);
        check(nv == 0 && nr == 1, "R5 reject on data rise", nr, 1);

        // R5 clock falls inside window
        bus_idle();
        observe(40, 0, 0, 3, 0, 8'h00, lat, nv, nr);
        check(nv == 0 && nr == 1, "R5 reject on clock fall", nr, 1);

        // R7 re-fall right after a glitch is not a new candidate
        bus_idle();
        observe(40, 2, 3, 0, 0, 8'h00, lat, nv, nr);
        check(nr == 1, "R7 single reject after glitch", nr, 1);
        check(nv == 0, "R7 re-fall ignored", nv, 0);

        // R8 setup write during a long window applies later
        bus_idle();
        write_reg(1'b0, 8'h94);
        observe(60, 0, 0, 0, 5, 8'h00, lat, nv, nr);
        check(lat == 24, "R8 count captured at detection", lat, 24);
        bus_idle();
        observe(30, 0, 0, 0, 0, 8'h00, lat, nv, nr);
        check(lat == 4, "R8 new count on next candidate", lat, 4);

        // R9 address register
        write_reg(1'b1, 8'hA7);
        rd_sel = 1'b1;
        #1 check(rd_data == 8'hA6, "R9 address bit0 reads zero", int'(rd_data), 8'hA6);
        check(own_addr == 7'h53, "R9 own_addr output", int'(own_addr), 7'h53);
        write_reg(1'b0, 8'hFF);
        rd_sel = 1'b0;
        #1 check(rd_data == 8'hFF, "R9 setup readback", int'(rd_data), 8'hFF);
        check(own_addr == 7'h53, "R9 setup write leaves address", int'(own_addr), 7'h53);

        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule